// File: doc/BRIEF.md
# Banked Data Register File with Pointer Resolution

This block holds the byte-wide data registers of a small microcontroller core. Storage is organised as sixteen banks of sixteen bytes plus a shared global bank of sixteen bytes. One slot of the global bank is the pointer register. It sits at file address 04h and can be read and written like any other location. Software loads, increments and bit-sets it through ordinary accesses.

The instruction side presents a 9-bit file address with a write strobe and a byte of write data, and gets back read data in the same cycle. A file address of 000h means "go through the pointer". The block then takes the full 8-bit pointer value as the effective address. Effective addresses 01h to 0Fh land in the global bank. Higher values pick a bank with their upper nibble and a register with their lower nibble. Bank 0 is never reachable through the pointer. The instruction side reaches it only through a fixed direct window, 100h to 10Fh.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register, the pointer included, reads 00h at every direct address.
- R2: The pointer is read and written at direct file address 004h. A value written there is used as the pointer from the next cycle on.
- R3: File address 000h resolves through the pointer. Pointer values 01h to 0Fh select global register number equal to the pointer value. These are the same storage as direct addresses 001h to 00Fh.
- R4: A pointer value of 10h or above selects bank pointer[7:4], register pointer[3:0]. For example, F5h is bank F register 5. Direct addresses 010h to 0FFh reach the same storage by the same split. Clearing pointer bit 7 moves the selection to bank pointer[6:4].
- R5: With the pointer at 00h, a read through address 000h returns 00h and a write through it changes nothing.
- R6: Bank 0 register n is reachable only at direct address 100h+n, with address bits 7:4 ignored. No access through address 000h ever modifies bank 0.
- R7: A write through address 000h while the pointer holds 04h replaces the pointer itself.
- R8: Writes take effect at the clock edge and reads are combinational. A read and a write to the same location in one cycle return the old data.
- R9: The pointer is a plain 8-bit register. A sweep that sets bit 3, clears the target through the pointer and adds one wraps from FFh to 00h after 128 passes. The sweep clears the upper half of the global bank and of banks 1 to F, and leaves bank 0 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 9 | File address: 000h through pointer, 001h-0FFh direct, 100h-10Fh bank 0 window |
| acc_we | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Combinational read data for acc_addr |

## Verification
Every location first gets a distinct value written through its direct address. All 256 pointer values are then read through address 000h. A wrong nibble split or a wrong global mapping therefore returns another location's value rather than a matching zero. A second sweep writes through the pointer at every value and reads everything back directly. That sweep tells apart a correct bank-0 guard, a working self-write at 04h and a discarded null write from a block that spills into bank 0 or the global bank. Same-cycle read/write, the bit-7 clear and the wrap-terminated clearing loop each isolate one ordering or boundary effect.

// File: rtl/rfile_pkg.sv
package rfile_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_W = 4;
    localparam int REG_W  = 4;
    localparam int EA_W   = BANK_W + REG_W;
    localparam int NBANK  = 1 << BANK_W;
    localparam int NREG   = 1 << REG_W;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_GLOBAL = 2'd1,
        TGT_BANK   = 2'd2
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e         kind;
        logic [BANK_W-1:0] bank;
        logic [REG_W-1:0]  idx;
    } tgt_t;
endpackage

// File: rtl/rfile_resolve.sv
module rfile_resolve
    import rfile_pkg::*;
#(
    parameter int FA_W = EA_W + 1
) (
    input  logic [FA_W-1:0] fa,
    input  logic [EA_W-1:0] fsr,
    output tgt_t            tgt
);
    logic            win;
    logic [EA_W-1:0] ea;
    logic            via_ptr;

    generate
        if (FA_W > EA_W) begin : g_win
            assign win = fa[FA_W-1];
        end else begin : g_nowin
            assign win = 1'b0;
        end
    endgenerate

    assign via_ptr = (fa[EA_W-1:0] == '0);
    assign ea      = via_ptr ? fsr : fa[EA_W-1:0];

    always_comb begin
        tgt.kind = TGT_NONE;
        tgt.bank = '0;
        tgt.idx  = ea[REG_W-1:0];
        if (win) begin
            tgt.kind = TGT_BANK;
            tgt.bank = '0;
            tgt.idx  = fa[REG_W-1:0];
        end else if (ea == '0) begin
            tgt.kind = TGT_NONE;
        end else if (ea[EA_W-1:REG_W] == '0) begin
            tgt.kind = TGT_GLOBAL;
        end else begin
            tgt.kind = TGT_BANK;
            tgt.bank = ea[EA_W-1:REG_W];
        end
    end
endmodule

// File: rtl/rfile_store.sv
module rfile_store
    import rfile_pkg::*;
#(
    parameter int FSR_SLOT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  tgt_t              tgt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [EA_W-1:0]   fsr
);
    localparam int NBYTE = NBANK * NREG;

    typedef struct {
        logic [DATA_W-1:0] glb [NREG];
        logic [DATA_W-1:0] bnk [NBYTE];
    } store_t;

    store_t st_d, st_q;
    logic [EA_W-1:0] slot;

    assign slot = {tgt.bank, tgt.idx};

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (tgt.kind)
                TGT_GLOBAL: st_d.glb[tgt.idx] = wdata;
                TGT_BANK:   st_d.bnk[slot]    = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)  st_q.glb[i] <= '0;
            for (int j = 0; j < NBYTE; j++) st_q.bnk[j] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (tgt.kind)
            TGT_GLOBAL: rdata = st_q.glb[tgt.idx];
            TGT_BANK:   rdata = st_q.bnk[slot];
            default:    rdata = '0;
        endcase
    end

    assign fsr = st_q.glb[FSR_SLOT][EA_W-1:0];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rfile_pkg::*;
#(
    parameter int FA_W     = EA_W + 1,
    parameter int FSR_SLOT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FA_W-1:0]   acc_addr,
    input  logic              acc_we,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata
);
    tgt_t            tgt_w;
    logic [EA_W-1:0] fsr_w;

    rfile_resolve #(.FA_W(FA_W)) u_res (
        .fa  (acc_addr),
        .fsr (fsr_w),
        .tgt (tgt_w)
    );

    rfile_store #(.FSR_SLOT(FSR_SLOT)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_we),
        .tgt   (tgt_w),
        .wdata (acc_wdata),
        .rdata (acc_rdata),
        .fsr   (fsr_w)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import rfile_pkg::*;
#(
    parameter int FA_W = EA_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FA_W-1:0]   acc_addr,
    input logic              acc_we,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic [EA_W-1:0]   fsr,
    input tgt_t              tgt
);
    logic via_ptr;
    assign via_ptr = (acc_addr == '0);

    // R2: direct write of the pointer slot is visible next cycle
    a_r2_direct_fsr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_addr == FA_W'(4)) |=> (fsr == $past(acc_wdata)));

    // R3: small pointer values land in the global bank
    a_r3_global_map: assert property (@(posedge clk) disable iff (!rst_n)
        (via_ptr && fsr != '0 && fsr[EA_W-1:REG_W] == '0)
        |-> (tgt.kind == TGT_GLOBAL && tgt.idx == fsr[REG_W-1:0]));

    // R5: null pointer reads zero
    a_r5_null_read: assert property (@(posedge clk) disable iff (!rst_n)
        (via_ptr && fsr == '0) |-> (acc_rdata == '0));

    // R5: null pointer write leaves pointer unchanged
    a_r5_null_write: assert property (@(posedge clk) disable iff (!rst_n)
        (via_ptr && acc_we && fsr == '0) |=> (fsr == '0));

    // R6: pointer access never selects bank 0
    a_r6_no_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        via_ptr |-> !(tgt.kind == TGT_BANK && tgt.bank == '0));

    // R7: pointer self-write
    a_r7_self_write: assert property (@(posedge clk) disable iff (!rst_n)
        (via_ptr && acc_we && fsr == EA_W'(4)) |=> (fsr == $past(acc_wdata)));
endmodule

bind banked_regfile banked_regfile_chk #(.FA_W(FA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (acc_addr),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .fsr       (fsr_w),
    .tgt       (tgt_w)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] acc_addr = '0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] m_glb [16];
    logic [7:0] m_bnk [256];

    always #10 clk = ~clk;

    banked_regfile u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    function automatic logic [7:0] ref_rd(input logic [8:0] a);
        logic [7:0] ea;
        if (a[8]) return m_bnk[a[3:0]];
        ea = (a[7:0] == 8'h00) ? m_glb[4] : a[7:0];
        if (ea == 8'h00) return 8'h00;
        if (ea < 8'h10) return m_glb[ea[3:0]];
        return m_bnk[ea];
    endfunction

    task automatic ref_wr(input logic [8:0] a, input logic [7:0] d);
        logic [7:0] ea;
        if (a[8]) begin
            m_bnk[a[3:0]] = d;
            return;
        end
        ea = (a[7:0] == 8'h00) ? m_glb[4] : a[7:0];
        if (ea == 8'h00) return;
        if (ea < 8'h10) m_glb[ea[3:0]] = d;
        else m_bnk[ea] = d;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_addr = a; acc_we = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
        ref_wr(a, d);
    endtask

    task automatic rd(input logic [8:0] a, input string req);
        @(negedge clk);
        acc_addr = a; acc_we = 1'b0;
        #2;
        check(req, acc_rdata, ref_rd(a));
    endtask

    // every direct address: 001h-0FFh and the bank-0 window
    task automatic read_all(input string req);
        for (int a = 1; a < 256; a++) rd(9'(a), req);
        for (int k = 0; k < 16; k++) rd(9'h100 + 9'(k), req);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_glb[i] = 8'h00;
        for (int i = 0; i < 256; i++) m_bnk[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state everywhere
        read_all("R1");

        // R3 R4 R6: distinct direct pattern, pointer slot left at 00h
        for (int a = 1; a < 256; a++)
            if (a != 4) wr(9'(a), 8'(a * 7 + 3));
        for (int k = 0; k < 16; k++) wr(9'h100 + 9'(k), 8'(k * 13 + 200));
        read_all("R4");

        // R5: null pointer read and write
        rd(9'h000, "R5");
        wr(9'h000, 8'hA5);
        read_all("R5");

        // R2 R3 R4: read through pointer at every value
        for (int p = 1; p < 256; p++) begin
            wr(9'h004, 8'(p));
            rd(9'h004, "R2");
            rd(9'h000, (p < 16) ? "R3" : "R4");
        end

        // R7: self-write through pointer at 04h
        wr(9'h004, 8'h04);
        wr(9'h000, 8'h3C);
        rd(9'h004, "R7");
        check("R7", acc_rdata, 8'h3C);

        // R4: bit 7 clear moves bank F to bank 7
        wr(9'h004, 8'hF5);
        rd(9'h000, "R4");
        check("R4", acc_rdata, 8'(8'hF5 * 7 + 3));
        wr(9'h004, 8'h75);
        rd(9'h000, "R4");
        check("R4", acc_rdata, 8'(8'h75 * 7 + 3));

        // R6 R7 R5: write through pointer at every value, then direct readback
        for (int p = 0; p < 256; p++) begin
            wr(9'h004, 8'(p));
            wr(9'h000, 8'(p ^ 8'h5A) ^ 8'hFF);
        end
        read_all("R6");
        for (int k = 0; k < 16; k++) begin
            rd(9'h1F0 + 9'(k), "R6");
            check("R6", acc_rdata, 8'(k * 13 + 200));
        end

        // R8: same-cycle write and read returns old data
        @(negedge clk);
        acc_addr = 9'h0A7; acc_we = 1'b1; acc_wdata = 8'h99;
        #2;
        check("R8", acc_rdata, ref_rd(9'h0A7));
        @(negedge clk);
        acc_we = 1'b0;
        ref_wr(9'h0A7, 8'h99);
        #2;
        check("R8", acc_rdata, 8'h99);

        // R9: wrap-terminated clearing loop
        begin
            int passes;
            logic [7:0] f;
            passes = 0;
            wr(9'h004, 8'h00);
            do begin
                rd(9'h004, "R9");
                wr(9'h004, acc_rdata | 8'h08);
                wr(9'h000, 8'h00);
                rd(9'h004, "R9");
                f = acc_rdata + 8'h01;
                wr(9'h004, f);
                passes++;
            end while (f != 8'h00 && passes < 300);
            n_run++;
            if (passes != 128) begin
                n_fail++;
                $display("FAIL R9 actual=%0d expected=128 passes", passes);
            end
            for (int a = 8; a < 256; a++)
                if (a[3]) check("R9", m_glb[0] | ref_rd(9'(a)), 8'h00);
            read_all("R9");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule